// File: doc/BRIEF.md
# Serial Zero-Count Threshold Detector

The block watches a data word that streams past one bit per valid clock, usually as a shift register unloads into a holding register. It counts the zero bits as they arrive, so no parallel adder tree and no magnitude comparator is needed. It raises two flags. One shows that at least half of the word is zero. The other shows that at least three quarters of the word is zero. With the default 16-bit word, these thresholds are a zero count of 8 or more and 12 or more. The results match a parallel detector that tests "zeros greater than 7" and "zeros greater than 11".

A start-of-word pulse clears the count and arms the block. After that, every cycle with the bit-valid strobe high delivers one bit. The word is sent MSB first, so the LSB is the last bit. The flags are decoded directly from the upper bits of the zero counter. The counter has one bit more than the word index needs, so an all-zero word cannot wrap the count back to zero. A one-cycle done pulse marks the cycle in which both flags are final. After the last bit, the block ignores further bits and holds its flags until the next start-of-word.

The design uses one rising-edge clock. A clock enable takes the place of a gated counter clock, and the reset is synchronous and active low.

Top module: `zero_thresh_serial`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ge_half_o`, `ge_3q_o` and `done_o` are all 0.
- R2: The zero count advances only on a cycle in which the block is armed, `bit_vld_i` is 1, `sow_i` is 0 and `bit_i` is 0. A one bit does not advance it, and neither does any bit presented with `bit_vld_i` low.
- R3: `ge_half_o` is 1 exactly when the zero count is at least WORD_BITS/2, which is 8 for the default word.
- R4: `ge_3q_o` is 1 exactly when the zero count is at least 3*WORD_BITS/4, which is 12 for the default word. It is never 1 while `ge_half_o` is 0.
- R5: A word made entirely of zeros gives a count of WORD_BITS without wrapping, and both flags read 1.
- R6: `done_o` is high for exactly one cycle. That cycle follows the clock edge that accepts the WORD_BITS-th valid bit, and both flags hold their final values for the word in that cycle.
- R7: After the last bit of a word, further valid bits of either value leave the flags unchanged and do not raise `done_o`, until the next `sow_i`.
- R8: `sow_i` clears the zero count, the flags and the bit position, and it arms the block. Any bit presented in the same cycle as `sow_i` is discarded, even when `bit_vld_i` is high.
- R9: Idle cycles (`bit_vld_i` low) may be inserted anywhere between bits without changing the flags or the done timing relative to the last valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; leaves the block armed with an empty count |
| sow_i | input | 1 | Start-of-word pulse: clears count, flags and position |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial data bit, MSB of the word first |
| ge_half_o | output | 1 | Zero count is at least WORD_BITS/2 |
| ge_3q_o | output | 1 | Zero count is at least 3*WORD_BITS/4 |
| done_o | output | 1 | One-cycle pulse: the last bit has been taken and the flags are final |

## Verification
The hardest case to reach is a count equal to the full word length. It arises only when every accepted bit is zero, and it is the case that would clear both flags if the counter wrapped. The sweep starts with the seventeen words that carry every zero count from none to all, with the zeros placed first at one end of the word and then at the other. A long run of pseudo-random words follows, each sent with pseudo-random idle gaps. Every word is also trailed by extra valid zero bits, and every few words a valid zero bit is presented in the same cycle as the start pulse. These two stimuli show whether bits outside the word's window are ignored.

// File: rtl/zc_pkg.sv
// Package: shared types for the serial zero-count threshold detector.
// Assumes: nothing beyond standard SystemVerilog.
package zc_pkg;

    // Pair of threshold results presented at the block's edge.
    typedef struct packed {
        logic ge_3q;    // zero count >= 3/4 of the word
        logic ge_half;  // zero count >= 1/2 of the word
    } zc_flags_t;

    // Width of a counter that must hold the value n itself (0..n).
    function automatic int unsigned zc_count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/zc_position_tracker.sv
// Module: tracks which bit of the word is next and whether a word is open.
// Produces the per-cycle accept strobe and a registered done pulse that is
// high in the cycle after the edge that takes the final bit.
// Assumes: WORD_BITS is a power of two of at least 4; sow_i wins over bits.
module zc_position_tracker #(
    parameter int unsigned WORD_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sow_i,
    input  logic bit_vld_i,
    output logic accept_o,
    output logic done_o
);
    localparam int unsigned PW = $clog2(WORD_BITS);
    localparam logic [PW-1:0] LAST_POS = PW'(WORD_BITS - 1);

    logic [PW-1:0] pos_q;
    logic          armed_q;
    logic          done_q;
    logic          last_bit;

    // A bit is taken only inside an open word and never alongside a start.
    assign accept_o = armed_q && bit_vld_i && !sow_i;
    assign last_bit = accept_o && (pos_q == LAST_POS);
    assign done_o   = done_q;

    // Position and open-word state: start opens, the final bit closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            armed_q <= 1'b1;
        end else if (sow_i) begin
            pos_q   <= '0;
            armed_q <= 1'b1;
        end else if (accept_o) begin
            pos_q <= pos_q + 1'b1;
            if (last_bit) begin
                armed_q <= 1'b0;
            end
        end
    end

    // One-cycle completion pulse, one stage behind the final accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= last_bit;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6

    AST_CLOSED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !sow_i) |-> !accept_o); // R7

endmodule

// File: rtl/zc_zero_counter.sv
// Module: counts accepted zero bits of the current word.
// The count is one bit wider than the word index, so a full word of zeros
// lands on WORD_BITS instead of wrapping to zero.
// Assumes: accept_i is already qualified by the position tracker.
module zc_zero_counter #(
    parameter int unsigned WORD_BITS = 16,
    parameter int unsigned CW        = zc_pkg::zc_count_width(WORD_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          accept_i,
    input  logic          bit_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] count_q;
    logic          step;

    // Clock enable replaces a data-gated counter clock.
    assign step    = accept_i && !bit_i;
    assign count_o = count_q;

    // Zero counter: clear on start, advance on each accepted zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (count_q >= $past(count_q))); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(WORD_BITS)); // R5

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == '0)); // R8

    AST_ONES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && (bit_i || !accept_i)) |=> $stable(count_q)); // R2

endmodule

// File: rtl/zc_flag_decode.sv
// Module: turns the zero count into the two threshold flags without a
// comparator. The top count bit alone means the whole word was zero; the
// next bit is the half-word weight and the one below it the quarter weight.
// Assumes: count never exceeds WORD_BITS (guaranteed by the counter).
module zc_flag_decode #(
    parameter int unsigned WORD_BITS = 16,
    parameter int unsigned CW        = zc_pkg::zc_count_width(WORD_BITS)
) (
    input  logic [CW-1:0]    count_i,
    output zc_pkg::zc_flags_t flags_o
);
    localparam int unsigned FULL_BIT = CW - 1;
    localparam int unsigned HALF_BIT = CW - 2;
    localparam int unsigned QTR_BIT  = CW - 3;

    generate
        if (WORD_BITS >= 4) begin : g_bit_decode
            // Threshold flags taken straight from the upper count bits.
            always_comb begin
                flags_o.ge_half = count_i[FULL_BIT] | count_i[HALF_BIT];
                flags_o.ge_3q   = count_i[FULL_BIT] |
                                  (count_i[HALF_BIT] & count_i[QTR_BIT]);
            end
        end else begin : g_tiny_word
            // Degenerate width: fall back to plain comparison.
            always_comb begin
                flags_o.ge_half = (count_i >= CW'(WORD_BITS / 2));
                flags_o.ge_3q   = (count_i >= CW'((3 * WORD_BITS) / 4));
            end
        end
    endgenerate

    always_comb begin
        AST_HI_NEEDS_LO: assert (!flags_o.ge_3q || flags_o.ge_half); // R4
    end

endmodule

// File: rtl/zero_thresh_serial.sv
// Module: top of the serial zero-count threshold detector.
// Counts zero bits of a WORD_BITS-bit word streamed MSB first and flags
// counts of at least half and at least three quarters of the word.
// Assumes: one rising-edge clock, synchronous active-low reset, WORD_BITS a
// power of two; flags are final in the cycle done_o is high and are held
// until the next sow_i.
module zero_thresh_serial #(
    parameter int unsigned WORD_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sow_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic ge_half_o,
    output logic ge_3q_o,
    output logic done_o
);
    localparam int unsigned CW = zc_pkg::zc_count_width(WORD_BITS);

    logic              accept;
    logic [CW-1:0]     zero_count;
    zc_pkg::zc_flags_t flags;

    zc_position_tracker #(
        .WORD_BITS (WORD_BITS)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .sow_i     (sow_i),
        .bit_vld_i (bit_vld_i),
        .accept_o  (accept),
        .done_o    (done_o)
    );

    zc_zero_counter #(
        .WORD_BITS (WORD_BITS),
        .CW        (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (sow_i),
        .accept_i (accept),
        .bit_i    (bit_i),
        .count_o  (zero_count)
    );

    zc_flag_decode #(
        .WORD_BITS (WORD_BITS),
        .CW        (CW)
    ) u_dec (
        .count_i (zero_count),
        .flags_o (flags)
    );

    assign ge_half_o = flags.ge_half;
    assign ge_3q_o   = flags.ge_3q;

    AST_FLAGS_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !sow_i) |=> ($stable(ge_half_o) && $stable(ge_3q_o))); // R7

    AST_START_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        sow_i |=> (!ge_half_o && !ge_3q_o)); // R8

endmodule

// File: tb/tb_zero_thresh_serial.sv
`timescale 1ns/1ps
module tb_zero_thresh_serial;
    localparam int unsigned W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sow_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic bit_i = 1'b0;
    logic ge_half_o, ge_3q_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    zero_thresh_serial #(.WORD_BITS(W)) dut (
        .clk(clk), .rst_n(rst_n), .sow_i(sow_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .ge_half_o(ge_half_o), .ge_3q_o(ge_3q_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Send one word MSB first; gaps selects idle cycles; junk puts a valid
    // zero bit beside the start pulse.
    task automatic send_word(input logic [15:0] w, input logic [15:0] gaps, input bit junk);
        int zeros = 0;
        logic exp_half, exp_3q;
        for (int i = 0; i < W; i++) zeros += (w[i] == 1'b0) ? 1 : 0;
        exp_half = (zeros > 7);
        exp_3q   = (zeros > 11);
        sow_i = 1'b1; bit_vld_i = junk; bit_i = 1'b0;
        @(negedge clk);
        sow_i = 1'b0;
        check("R8", ge_half_o, 1'b0, "half flag after start");
        check("R8", ge_3q_o, 1'b0, "3q flag after start");
        for (int i = 0; i < W; i++) begin
            if (gaps[i]) begin
                bit_vld_i = 1'b0; bit_i = 1'b0;   // R9 idle zero must not count (R2)
                @(negedge clk);
            end
            bit_vld_i = 1'b1; bit_i = w[W-1-i];
            @(negedge clk);
            if (i == W - 2) check("R6", done_o, 1'b0, "done before last bit");
        end
        bit_vld_i = 1'b0; bit_i = 1'b0;
        check("R6", done_o, 1'b1, "done after last bit");
        check("R3", ge_half_o, exp_half, $sformatf("half flag word %h", w));
        check("R4", ge_3q_o, exp_3q, $sformatf("3q flag word %h", w));
        if (w == 16'h0000) check("R5", ge_3q_o & ge_half_o, 1'b1, "all-zero word");
        // Trailing valid zeros after the word must change nothing (R7).
        for (int k = 0; k < 2; k++) begin
            bit_vld_i = 1'b1; bit_i = 1'b0;
            @(negedge clk);
            check("R7", done_o, 1'b0, "done after trailing bit");
            check("R7", ge_half_o, exp_half, "half held");
            check("R7", ge_3q_o, exp_3q, "3q held");
        end
        bit_vld_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ge_half_o, 1'b0, "half in reset");
        check("R1", ge_3q_o, 1'b0, "3q in reset");
        check("R1", done_o, 1'b0, "done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", done_o | ge_half_o | ge_3q_o, 1'b0, "outputs after reset");
        // Every zero count, zeros at the low end then at the high end.
        for (int k = 0; k <= W; k++) begin
            send_word(16'hFFFF << k, 16'h0000, 1'b0);
            send_word(16'hFFFF >> k, 16'h8421, k[0]);
        end
        // Pseudo-random words with pseudo-random gaps (R2, R9).
        for (int n = 0; n < 2500; n++) begin
            logic [15:0] w;
            logic [15:0] g;
            step_lfsr(); w = lfsr;
            step_lfsr(); g = lfsr & {lfsr[7:0], lfsr[15:8]};
            send_word(w, g, (n % 5) == 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule